// File: doc/BRIEF.md
# Recirculating Longest-Prefix-Match Engine

This engine resolves the longest-prefix match of 32-bit addresses against a three-level trie held in an external table memory. The first level is indexed directly by the top 16 address bits. A second or third read follows only while the returned entry is a pointer, indexed by the next 8 address bits added to that pointer. A lookup uses the memory port once per level it actually needs. The engine keeps at most one memory request per cycle, and the memory answers each request a fixed number of cycles later.

A lookup enters only when a sequence token is offered by the external reorder stage. That stage hands out tokens and puts the results back in arrival order. At entry the engine issues the first-level read and parks the remaining 16 address bits, the token and the level in a small in-flight queue until the response comes back. On each response the queue head is popped. A leaf produces a token-tagged result, while a pointer sends the lookup around again with a fresh read. Because short lookups leave early, results come out in completion order, not arrival order.

Table entries are `ADDR_W+1` bits wide. The top bit is the leaf flag (1 = leaf). The low `ADDR_W` bits hold the pointer of a non-leaf entry, and the low `VAL_W` bits hold the value of a leaf.

Top module: `prefix_walker`

## Requirements
- R1: A lookup is accepted (`tok_take` high) only in a cycle where `in_valid` and `tok_avail` are both high and no recirculating read is due. In that same cycle `mem_req_valid` is high and `mem_req_addr` equals `in_addr[31:16]`, zero-extended.
- R2: A response whose top bit is 1 yields, one cycle later, `res_valid` with the token that issued the read and `res_value` equal to the low `VAL_W` bits of the response.
- R3: A response whose top bit is 0, to a first- or second-level read, issues a read in the response cycle. That read goes to the pointer (low `ADDR_W` bits) plus the next 8 unconsumed address bits, `in_addr[15:8]` after level one and `in_addr[7:0]` after level two. The lookup keeps its token.
- R4: A response to a third-level read is treated as a leaf whatever its top bit, so every lookup makes at most three reads.
- R5: In a cycle where a recirculating read is due, no new lookup is accepted (`in_ready` low) and the port carries the recirculating read.
- R6: When no recirculation is due and a token is offered, a lookup is accepted in every cycle. Entries and responses may share a cycle with no dead cycle between them.
- R7: A lookup needing k reads produces its result exactly k*LAT+1 cycles after acceptance (LAT = 4), so a shorter lookup entered later can finish first. Every accepted lookup produces exactly one result.
- R8: During and right after reset, `res_valid` and `mem_req_valid` are low. With no lookup in flight and a token offered, `in_ready` is high.
- R9: The in-flight queue holds one entry per outstanding read. It never exceeds its depth, and it is never empty when a response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An address waits to enter |
| in_addr | input | 32 | Address to look up |
| in_ready | output | 1 | Entry possible this cycle (token offered, port free, queue room) |
| tok_avail | input | 1 | Reorder stage offers a token |
| tok_id | input | TOK_W | Offered token |
| tok_take | output | 1 | Token consumed, lookup accepted |
| mem_req_valid | output | 1 | Table read request |
| mem_req_addr | output | ADDR_W | Table read address |
| mem_rsp_valid | input | 1 | Table read response, LAT cycles after its request |
| mem_rsp_data | input | ADDR_W+1 | Table entry: leaf flag on top, pointer or value below |
| res_valid | output | 1 | Lookup result valid |
| res_token | output | TOK_W | Token of the finished lookup |
| res_value | output | VAL_W | Matched value |

## Verification
On every cycle, the assertions check that a taken token coincides with a first-level request and that a leaf or third-level response becomes a result one cycle later. They also check that a recirculating pointer response blocks entry, and that the in-flight queue neither overflows nor meets a response while empty. Other properties can be shown only through the bench's scenarios against a table model: the value each lookup finally returns, its exact k*LAT+1 latency, and that a short lookup overtakes a long one. The same holds for back-to-back acceptance without dead cycles and for the forced leaf at level three when the flag bit is 0.

// File: rtl/prefix_walker.sv
module prefix_walker #(
  parameter int ADDR_W = 20,
  parameter int VAL_W  = 16,
  parameter int TOK_W  = 4,
  parameter int LAT    = 4,
  parameter int DEPTH  = 2 * LAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_addr,
  output logic              in_ready,
  input  logic              tok_avail,
  input  logic [TOK_W-1:0]  tok_id,
  output logic              tok_take,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W:0]   mem_rsp_data,
  output logic              res_valid,
  output logic [TOK_W-1:0]  res_token,
  output logic [VAL_W-1:0]  res_value
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [15:0]      q_rem [DEPTH];
  logic [TOK_W-1:0] q_tok [DEPTH];
  logic [1:0]       q_lvl [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;

  logic [15:0]      head_rem;
  logic [TOK_W-1:0] head_tok;
  logic [1:0]       head_lvl;
  logic             rsp_leaf, recirc, enq, deq, room;

  assign head_rem = q_rem[rd_ptr];
  assign head_tok = q_tok[rd_ptr];
  assign head_lvl = q_lvl[rd_ptr];

  assign rsp_leaf = mem_rsp_data[ADDR_W] || (head_lvl == 2'd2);
  assign recirc   = mem_rsp_valid && !rsp_leaf;
  assign deq      = mem_rsp_valid;
  assign room     = (cnt != CW'(DEPTH)) || deq;

  assign in_ready = tok_avail && !recirc && room;
  assign tok_take = in_valid && in_ready;
  assign enq      = recirc || tok_take;

  assign mem_req_valid = enq;
  assign mem_req_addr  = recirc ? mem_rsp_data[ADDR_W-1:0] + ADDR_W'(head_rem[15:8])
                                : ADDR_W'(in_addr[31:16]);

  always_ff @(posedge clk) begin
    if (enq) begin
      q_rem[wr_ptr] <= recirc ? {head_rem[7:0], 8'h00} : in_addr[15:0];
      q_tok[wr_ptr] <= recirc ? head_tok : tok_id;
      q_lvl[wr_ptr] <= recirc ? head_lvl + 2'd1 : 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      res_valid <= 1'b0;
      res_token <= '0;
      res_value <= '0;
    end else begin
      if (enq) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (deq) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt       <= cnt + CW'(enq) - CW'(deq);
      res_valid <= mem_rsp_valid && rsp_leaf;
      if (mem_rsp_valid && rsp_leaf) begin
        res_token <= head_tok;
        res_value <= mem_rsp_data[VAL_W-1:0];
      end
    end
  end
endmodule

module prefix_walker_chk #(
  parameter int ADDR_W = 20,
  parameter int VAL_W  = 16,
  parameter int TOK_W  = 4,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [31:0]       in_addr,
  input logic              tok_avail,
  input logic              tok_take,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [ADDR_W:0]   mem_rsp_data,
  input logic              res_valid,
  input logic [VAL_W-1:0]  res_value,
  input logic [1:0]        head_lvl,
  input logic [$clog2(DEPTH+1)-1:0] cnt
);
  p_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tok_take |-> tok_avail && in_valid && mem_req_valid
                 && mem_req_addr == ADDR_W'(in_addr[31:16]));

  p_leaf_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && mem_rsp_data[ADDR_W] |=>
      res_valid && res_value == $past(mem_rsp_data[VAL_W-1:0]));

  p_recirc_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && !mem_rsp_data[ADDR_W] && head_lvl != 2'd2 |-> mem_req_valid);

  p_third_leaf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && head_lvl == 2'd2 |=> res_valid);

  p_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && !mem_rsp_data[ADDR_W] && head_lvl != 2'd2 |-> !in_ready && !tok_take);

  p_result_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(mem_rsp_valid));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH+1))'(DEPTH));

  p_rsp_has_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> cnt != '0);
endmodule

bind prefix_walker prefix_walker_chk #(
  .ADDR_W(ADDR_W), .VAL_W(VAL_W), .TOK_W(TOK_W), .DEPTH(DEPTH)
) u_chk (.*);

// File: tb/prefix_walker_test.sv
`timescale 1ns/1ps
module prefix_walker_test;
  localparam int AW = 20, VW = 16, TW = 4, LAT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          in_valid = 0, in_ready, tok_avail = 0, tok_take;
  logic [31:0]   in_addr = '0;
  logic [TW-1:0] tok_id = '0;
  logic          mem_req_valid, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [AW:0]   mem_rsp_data;
  logic          res_valid;
  logic [TW-1:0] res_token;
  logic [VW-1:0] res_value;

  prefix_walker uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_ready(in_ready),
    .tok_avail(tok_avail), .tok_id(tok_id), .tok_take(tok_take),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_token(res_token), .res_value(res_value));

  function automatic logic [AW:0] tbl(input logic [AW-1:0] a);
    logic [15:0] o;
    o = a[15:0];
    if (a[19:16] == 4'h0) begin
      if (o[15:12] == 4'hA) return {1'b0, 20'h10000 + 20'({o[7:0], 8'h00})};
      return {1'b1, 4'h0, o ^ 16'h5A5A};
    end else if (a[19:16] == 4'h1) begin
      if (o[0]) return {1'b0, 20'h20000 + 20'({o[15:8] ^ o[7:0], 8'h00})};
      return {1'b1, 4'h0, o ^ 16'h1234};
    end
    return {a[0], 4'h0, o + 16'h0777};
  endfunction

  function automatic logic [VW-1:0] gold(input logic [31:0] a, output int lv);
    logic [AW:0] e;
    e = tbl(20'(a[31:16])); lv = 1;
    if (e[AW]) return e[15:0];
    e = tbl(e[AW-1:0] + 20'(a[15:8])); lv = 2;
    if (e[AW]) return e[15:0];
    e = tbl(e[AW-1:0] + 20'(a[7:0])); lv = 3;
    return e[15:0];
  endfunction

  function automatic logic [31:0] mk(input int kind, input logic [31:0] r);
    logic [31:0] a = r;
    if (kind == 1) begin if (a[31:28] == 4'hA) a[31:28] = 4'h5; end
    else begin a[31:28] = 4'hA; a[8] = (kind == 3); end
    return a;
  endfunction

  logic          mv [LAT];
  logic [AW-1:0] ma [LAT];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) mv[i] <= 1'b0;
    end else begin
      mv[0] <= mem_req_valid; ma[0] <= mem_req_addr;
      for (int i = 1; i < LAT; i++) begin mv[i] <= mv[i-1]; ma[i] <= ma[i-1]; end
    end
  end
  assign mem_rsp_valid = mv[LAT-1];
  assign mem_rsp_data  = tbl(ma[LAT-1]);

  int total = 0, bad = 0, cyc = 0, seq_no = 0, n_acc = 0, n_done = 0;
  logic [VW-1:0] exp_val [16];
  int exp_lvl [16], t_in [16], arr_seq [16];
  bit busy [16];
  logic [TW-1:0] next_tok = '0;
  bit acc;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] a, input bit gate);
    int t, lv;
    @(negedge clk);
    cyc++;
    if (rst_n && res_valid) begin
      t = int'(res_token);
      if (!busy[t]) chk(0, "R7", "result for idle token", t, 0);
      else begin
        chk(res_value == exp_val[t], exp_lvl[t] == 1 ? "R2" : (exp_lvl[t] == 2 ? "R3" : "R4"),
            "result value", res_value, exp_val[t]);
        chk(cyc - t_in[t] == exp_lvl[t] * LAT + 1, "R7", "result latency",
            cyc - t_in[t], exp_lvl[t] * LAT + 1);
        busy[t] = 0; arr_seq[t] = seq_no++; n_done++;
      end
    end
    in_valid = v; in_addr = a; tok_id = next_tok;
    tok_avail = gate && !busy[int'(next_tok)];
    #1;
    acc = in_valid && in_ready;
    if (acc) begin
      chk(mem_req_valid && tok_take && mem_req_addr == 20'(a[31:16]), "R1",
          "first-level read address", mem_req_addr, a[31:16]);
      t = int'(next_tok);
      busy[t] = 1; exp_val[t] = gold(a, lv); exp_lvl[t] = lv; t_in[t] = cyc;
      next_tok++; n_acc++;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && n_done != n_acc; i++) step(0, '0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a1, a2, a3, pend;
    logic [TW-1:0] tl, ts;
    int lv, na;
    bit have;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) busy[i] = 0;

    repeat (3) begin
      @(negedge clk);
      chk(!res_valid && !mem_req_valid, "R8", "idle during reset", {res_valid, mem_req_valid}, 0);
    end
    rst_n = 1'b1;
    step(0, '0, 1);
    chk(in_ready && !res_valid && !mem_req_valid, "R8", "ready after reset",
        {in_ready, res_valid, mem_req_valid}, 3'b100);

    // R1: no token, no entry
    a1 = mk(1, $urandom);
    for (int i = 0; i < 4; i++) begin
      step(1, a1, 0);
      chk(!acc && !mem_req_valid, "R1", "entry without token", {acc, mem_req_valid}, 0);
    end

    // R7: long lookup overtaken by a short one
    a3 = mk(3, $urandom); a3[0] = 1'b1;
    tl = next_tok; step(1, a3, 1);
    ts = next_tok; step(1, a1, 1);
    drain();
    chk(arr_seq[int'(ts)] < arr_seq[int'(tl)], "R7", "short lookup finishes first",
        arr_seq[int'(ts)], arr_seq[int'(tl)]);

    // R4: third-level entry with flag 0 is still a leaf
    a3 = mk(3, $urandom); a3[0] = 1'b0;
    step(1, a3, 1);
    drain();
    chk(n_done == n_acc, "R4", "forced leaf returned", n_done, n_acc);

    // R5 / R3: recirculation takes the port
    a2 = mk(2, $urandom);
    step(1, a2, 1);
    repeat (3) step(0, '0, 1);
    step(1, a1, 1);
    chk(!acc && !in_ready, "R5", "entry blocked by recirculation", acc, 0);
    chk(mem_req_valid && mem_req_addr == tbl(20'(a2[31:16]))[AW-1:0] + 20'(a2[15:8]),
        "R3", "second-level read address", mem_req_addr,
        tbl(20'(a2[31:16]))[AW-1:0] + 20'(a2[15:8]));
    step(1, a1, 1);
    chk(acc, "R5", "entry resumes next cycle", acc, 1);
    drain();

    // R6: back-to-back single-level entries
    na = 0;
    for (int i = 0; i < 10; i++) begin
      step(1, mk(1, $urandom), 1);
      na += int'(acc);
    end
    chk(na == 10, "R6", "entries without dead cycles", na, 10);
    drain();

    // random mix
    have = 0; pend = '0;
    for (int i = 0; i < 3000; i++) begin
      if (!have) begin pend = mk(1 + ($urandom % 3), $urandom); have = 1; end
      step(($urandom % 10) < 8, pend, ($urandom % 10) < 9);
      if (acc) have = 0;
    end
    drain();
    chk(n_done == n_acc, "R7", "one result per lookup", n_done, n_acc);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule